// File: doc/BRIEF.md
# DMA Channel Pointer Engine with Reload

This block keeps the address and item-count state for a multi-channel engine that moves data between peripherals and memory. Each channel holds a current address and count, a second address/count pair that is queued behind them, a mode field, and interrupt flags. When a peripheral raises its request line and the channel is armed, the engine issues one single-item transfer on the bus side. When that transfer completes, the channel's address moves forward by the item size and its count drops by one. When the count runs out and a queued pair is waiting, the queued pair moves into the current registers without any software action. This lets software refill one buffer while the other is being used.

Software reaches every channel through a flat register window, with one 64-byte slot per channel. In ring mode the queued pair is kept after it is copied, so one buffer is walked again and again. When several channels request at the same time, a fixed-priority arbiter serves the lowest-numbered eligible channel. A bus error stops the channel and raises a sticky flag, which software clears through the control word.

Top module: `dma_ptr_engine`

## Requirements
- R1: Channel n's registers sit at byte offset n*0x40 plus a word offset: current address 0x00, peripheral select 0x04 (8 bits), current count 0x08, queued address 0x0C, queued count 0x10, control 0x14 (write-only), mode 0x18, status 0x1C (bit0 = enabled), interrupt-enable 0x20 (write-only), interrupt-disable 0x24 (write-only), interrupt mask 0x28, interrupt flags 0x2C. Write-only words read as zero, and after reset every register reads zero except the flags word.
- R2: Each completed transfer without error adds the item size to the current address and subtracts one from the current count. The size comes from mode bits [1:0]: 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes. The size code is shown on `xfer_size`.
- R3: If the count reaches zero on a completion and the queued count is nonzero, the queued address and count are copied into the current registers. Outside ring mode, both queued registers then read zero.
- R4: A write to the queued count while the current count is zero and the written value is nonzero copies the queued address and the written count into the current registers at once. In any other case the write only updates the queued count.
- R5: With mode bit 2 (ring) set, the queued address and count keep their values after every copy of R3 or R4.
- R6: Among channels that are requesting, enabled and have a nonzero count, the lowest channel index is granted.
- R7: `xfer_valid` stays high with a constant `xfer_ch` and `xfer_addr` until `bus_done`. An error-free completion pulses exactly one `dma_ack` bit, the granted channel's. Each grant carries exactly one transfer, and `xfer_valid` is low in the cycle after a completion.
- R8: A completion with `bus_err` high disables the channel (status bit0 = 0), sets flag bit2, leaves the address and count unchanged, and gives no ack. Writing control bit8 clears flag bit2.
- R9: Flags word: bit0 = queued count is zero, bit1 = current count is zero, bit2 = error. A one written to an interrupt-enable or interrupt-disable bit sets or clears that mask bit, and zeros leave the mask unchanged. `irq[n]` is the OR of channel n's flags ANDed with its mask.
- R10: Control bit0 enables a channel and bit1 disables it. A request from a disabled channel, or from a channel whose count is zero, starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CHW+6 | Register byte address (channel slot and word offset) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| dma_req | input | NCH | Per-channel peripheral request |
| dma_ack | output | NCH | Per-channel acknowledge on error-free completion |
| xfer_valid | output | 1 | A single-item transfer is outstanding |
| xfer_ch | output | CHW | Channel that owns the outstanding transfer |
| xfer_addr | output | 32 | Memory address of the outstanding transfer |
| xfer_size | output | 2 | Size code of the outstanding transfer |
| bus_done | input | 1 | Bus completes the outstanding transfer |
| bus_err | input | 1 | Qualifies `bus_done` as an error response |
| irq | output | NCH | Per-channel interrupt |

## Verification
The hardest state to reach from the ports is the handover to the queued pair, in both plain and ring mode. The bench reaches it by loading a short count together with a queued pair, then driving completions until the count runs out. It then reads the current and queued registers and checks the address of the transfer that follows. The immediate load is reached by writing a queued count into a channel that has never counted, and arbitration is tested by raising two requests in the same cycle. The error path uses a completion with `bus_err` set, followed by mask writes of ones and zeros, and the interrupt line is checked before and after the flag is cleared.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int DATA_W = 32;
    localparam int NFLG   = 3;

    // word offsets inside one channel slot
    typedef enum logic [3:0] {
        RG_ADDR     = 4'd0,
        RG_PSEL     = 4'd1,
        RG_CNT      = 4'd2,
        RG_ADDR_RLD = 4'd3,
        RG_CNT_RLD  = 4'd4,
        RG_CTRL     = 4'd5,
        RG_MODE     = 4'd6,
        RG_STAT     = 4'd7,
        RG_IEN      = 4'd8,
        RG_IDIS     = 4'd9,
        RG_IMASK    = 4'd10,
        RG_IFLAG    = 4'd11
    } reg_sel_e;

    localparam int FLG_RLD_EMPTY = 0;
    localparam int FLG_DONE      = 1;
    localparam int FLG_ERR       = 2;

    localparam int CTL_ENABLE  = 0;
    localparam int CTL_DISABLE = 1;
    localparam int CTL_ERR_CLR = 8;

    typedef struct packed {
        logic       ring;
        logic [1:0] size;
    } mode_t;

    function automatic logic [2:0] step_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    step_bytes = 3'd1;
            2'd1:    step_bytes = 3'd2;
            default: step_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
    parameter int NCH = 4,
    parameter int CHW = 2
) (
    input  logic [NCH-1:0] elig,
    output logic           any,
    output logic [CHW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (elig[i]) idx = i[CHW-1:0];
        end
        any = |elig;
    end
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq #(
    parameter int NCH = 4,
    parameter int CHW = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] elig,
    input  logic           bus_done,
    input  logic           bus_err,
    output logic           xfer_valid,
    output logic [CHW-1:0] xfer_ch,
    output logic [NCH-1:0] ok_vec,
    output logic [NCH-1:0] fail_vec
);
    logic           busy;
    logic [CHW-1:0] cur;
    logic           arb_any;
    logic [CHW-1:0] arb_idx;

    dma_prio_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
        .elig (elig),
        .any  (arb_any),
        .idx  (arb_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cur  <= '0;
        end else if (busy) begin
            if (bus_done) busy <= 1'b0;
        end else if (arb_any) begin
            busy <= 1'b1;
            cur  <= arb_idx;
        end
    end

    assign xfer_valid = busy;
    assign xfer_ch    = cur;

    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        assign ok_vec[g]   = busy && bus_done && !bus_err && (cur == CHW'(g));
        assign fail_vec[g] = busy && bus_done &&  bus_err && (cur == CHW'(g));
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [3:0]        wr_reg,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              xfer_ok,
    input  logic              xfer_fail,
    input  logic [3:0]        rd_reg,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] cur_addr,
    output logic [1:0]        cur_size,
    output logic              ready,
    output logic              irq
);
    logic [DATA_W-1:0] mar, marr;
    logic [CW-1:0]     tcr, tcrr, cnt_dec, wr_cnt;
    logic [7:0]        psel;
    mode_t             mode;
    logic              en, err;
    logic [NFLG-1:0]   imr, flags;
    logic [DATA_W-1:0] next_addr;

    assign cnt_dec   = tcr - CW'(1);
    assign wr_cnt    = wr_data[CW-1:0];
    assign next_addr = mar + DATA_W'(step_bytes(mode.size));

    always_ff @(posedge clk) begin
        if (rst) begin
            mar  <= '0;
            marr <= '0;
            tcr  <= '0;
            tcrr <= '0;
            psel <= '0;
            mode <= '0;
            en   <= 1'b0;
            err  <= 1'b0;
            imr  <= '0;
        end else begin
            // completion side
            if (xfer_fail) begin
                en  <= 1'b0;
                err <= 1'b1;
            end else if (xfer_ok) begin
                if (cnt_dec == '0 && tcrr != '0) begin
                    mar <= marr;
                    tcr <= tcrr;
                    if (!mode.ring) begin
                        marr <= '0;
                        tcrr <= '0;
                    end
                end else begin
                    mar <= next_addr;
                    tcr <= cnt_dec;
                end
            end
            // software side, later assignment wins
            if (wr_en) begin
                case (reg_sel_e'(wr_reg))
                    RG_ADDR:     mar  <= wr_data;
                    RG_PSEL:     psel <= wr_data[7:0];
                    RG_CNT:      tcr  <= wr_cnt;
                    RG_ADDR_RLD: marr <= wr_data;
                    RG_CNT_RLD: begin
                        if (tcr == '0 && wr_cnt != '0) begin
                            mar <= marr;
                            tcr <= wr_cnt;
                            if (mode.ring) begin
                                tcrr <= wr_cnt;
                            end else begin
                                marr <= '0;
                                tcrr <= '0;
                            end
                        end else begin
                            tcrr <= wr_cnt;
                        end
                    end
                    RG_CTRL: begin
                        if (wr_data[CTL_ENABLE])  en  <= 1'b1;
                        if (wr_data[CTL_DISABLE]) en  <= 1'b0;
                        if (wr_data[CTL_ERR_CLR]) err <= 1'b0;
                    end
                    RG_MODE: mode <= mode_t'(wr_data[2:0]);
                    RG_IEN:  imr  <= imr | wr_data[NFLG-1:0];
                    RG_IDIS: imr  <= imr & ~wr_data[NFLG-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        flags                = '0;
        flags[FLG_RLD_EMPTY] = (tcrr == '0);
        flags[FLG_DONE]      = (tcr == '0);
        flags[FLG_ERR]       = err;
    end

    assign irq      = |(flags & imr);
    assign ready    = en && (tcr != '0);
    assign cur_addr = mar;
    assign cur_size = mode.size;

    always_comb begin
        case (reg_sel_e'(rd_reg))
            RG_ADDR:     rd_data = mar;
            RG_PSEL:     rd_data = DATA_W'(psel);
            RG_CNT:      rd_data = DATA_W'(tcr);
            RG_ADDR_RLD: rd_data = marr;
            RG_CNT_RLD:  rd_data = DATA_W'(tcrr);
            RG_MODE:     rd_data = DATA_W'(mode);
            RG_STAT:     rd_data = DATA_W'(en);
            RG_IMASK:    rd_data = DATA_W'(imr);
            RG_IFLAG:    rd_data = DATA_W'(flags);
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dma_ptr_engine.sv
module dma_ptr_engine
    import dma_pkg::*;
#(
    parameter  int NCH    = 4,
    parameter  int CW     = 16,
    localparam int CHW    = $clog2(NCH),
    localparam int CFG_AW = CHW + 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [NCH-1:0]    dma_req,
    output logic [NCH-1:0]    dma_ack,
    output logic              xfer_valid,
    output logic [CHW-1:0]    xfer_ch,
    output logic [31:0]       xfer_addr,
    output logic [1:0]        xfer_size,
    input  logic              bus_done,
    input  logic              bus_err,
    output logic [NCH-1:0]    irq
);
    logic [CHW-1:0]    sel_ch;
    logic [3:0]        sel_reg;
    logic [NCH-1:0]    ready_vec, elig, ok_vec, fail_vec;
    logic [DATA_W-1:0] rd_arr   [NCH];
    logic [DATA_W-1:0] addr_arr [NCH];
    logic [1:0]        size_arr [NCH];
    logic              unused_cfg;

    assign sel_ch     = cfg_addr[CFG_AW-1:6];
    assign sel_reg    = cfg_addr[5:2];
    assign unused_cfg = ^cfg_addr[1:0];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dma_chan_regs #(.CW(CW)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (cfg_we && (sel_ch == CHW'(g))),
            .wr_reg    (sel_reg),
            .wr_data   (cfg_wdata),
            .xfer_ok   (ok_vec[g]),
            .xfer_fail (fail_vec[g]),
            .rd_reg    (sel_reg),
            .rd_data   (rd_arr[g]),
            .cur_addr  (addr_arr[g]),
            .cur_size  (size_arr[g]),
            .ready     (ready_vec[g]),
            .irq       (irq[g])
        );
    end

    assign elig = dma_req & ready_vec;

    dma_xfer_seq #(.NCH(NCH), .CHW(CHW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .elig       (elig),
        .bus_done   (bus_done),
        .bus_err    (bus_err),
        .xfer_valid (xfer_valid),
        .xfer_ch    (xfer_ch),
        .ok_vec     (ok_vec),
        .fail_vec   (fail_vec)
    );

    assign dma_ack   = ok_vec;
    assign xfer_addr = addr_arr[xfer_ch];
    assign xfer_size = size_arr[xfer_ch];
    assign cfg_rdata = rd_arr[sel_ch];
endmodule

// File: rtl/dma_ptr_engine_chk.sv
module dma_ptr_engine_chk #(
    parameter int NCH = 4,
    parameter int CHW = 2
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] dma_req,
    input logic [NCH-1:0] dma_ack,
    input logic           xfer_valid,
    input logic [CHW-1:0] xfer_ch,
    input logic [31:0]    xfer_addr,
    input logic           bus_done,
    input logic           bus_err,
    input logic [NCH-1:0] elig
);
    logic [NCH-1:0] low_m;
    assign low_m = (NCH'(1) << xfer_ch) - NCH'(1);

    assert_grant_hold_R7: assert property (@(posedge clk) disable iff (rst)
        xfer_valid && !bus_done |=> xfer_valid && $stable(xfer_ch));

    assert_ack_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dma_ack));

    assert_ack_cause_R7: assert property (@(posedge clk) disable iff (rst)
        (dma_ack != '0) |-> xfer_valid && bus_done && !bus_err
                            && ((dma_ack >> xfer_ch) == NCH'(1)));

    assert_one_per_grant_R7: assert property (@(posedge clk) disable iff (rst)
        xfer_valid && bus_done |=> !xfer_valid);

    assert_err_no_ack_R8: assert property (@(posedge clk) disable iff (rst)
        xfer_valid && bus_done && bus_err |-> dma_ack == '0);

    assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_valid) |-> ((($past(elig) >> xfer_ch) & NCH'(1)) != '0)
                              && (($past(elig) & low_m) == '0));

    assert_needs_req_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_valid) |-> ((($past(dma_req) >> xfer_ch) & NCH'(1)) != '0));
endmodule

bind dma_ptr_engine dma_ptr_engine_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dma_req    (dma_req),
    .dma_ack    (dma_ack),
    .xfer_valid (xfer_valid),
    .xfer_ch    (xfer_ch),
    .xfer_addr  (xfer_addr),
    .bus_done   (bus_done),
    .bus_err    (bus_err),
    .elig       (elig)
);

// File: tb/sim_dma_ptr_engine.sv
`timescale 1ns/1ps
module sim_dma_ptr_engine;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [3:0]  dma_req = '0;
    logic [3:0]  dma_ack;
    logic        xfer_valid;
    logic [1:0]  xfer_ch;
    logic [31:0] xfer_addr;
    logic [1:0]  xfer_size;
    logic        bus_done = 1'b0;
    logic        bus_err = 1'b0;
    logic [3:0]  irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dma_ptr_engine #(.NCH(NCH), .CW(16)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dma_req(dma_req),
        .dma_ack(dma_ack), .xfer_valid(xfer_valid), .xfer_ch(xfer_ch),
        .xfer_addr(xfer_addr), .xfer_size(xfer_size), .bus_done(bus_done),
        .bus_err(bus_err), .irq(irq)
    );

    // word offsets
    localparam int O_ADDR = 0, O_PSEL = 1, O_CNT = 2, O_ARLD = 3, O_CRLD = 4,
                   O_CTRL = 5, O_MODE = 6, O_STAT = 7, O_IEN = 8, O_IDIS = 9,
                   O_IMSK = 10, O_IFLG = 11;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input int ch, input int r, input logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 8'(ch * 64 + r * 4);
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int ch, input int r, input logic [31:0] exp);
        @(negedge clk);
        cfg_addr = 8'(ch * 64 + r * 4);
        #1;
        chk(tag, cfg_rdata, exp);
    endtask

    task automatic do_xfer(input string tag, input int ch, input logic [31:0] exp_addr,
                           input logic [1:0] exp_size, input logic err);
        @(negedge clk);
        dma_req[ch] = 1'b1;
        for (int i = 0; i < 10 && !xfer_valid; i++) @(negedge clk);
        chk({tag, " ch"}, 32'(xfer_ch), 32'(ch));
        chk({tag, " addr"}, xfer_addr, exp_addr);
        chk({tag, " size"}, 32'(xfer_size), 32'(exp_size));
        bus_done = 1'b1;
        bus_err  = err;
        #1;
        chk({tag, " ack"}, 32'(dma_ack), err ? 32'h0 : 32'(1 << ch));
        @(negedge clk);
        bus_done    = 1'b0;
        bus_err     = 1'b0;
        dma_req[ch] = 1'b0;
        #1;
        chk({tag, " R7 valid low after done"}, 32'(xfer_valid), 32'h0);
    endtask

    task automatic t_reset;
        chk("R1 reset valid", 32'(xfer_valid), 32'h0);
        chk("R9 reset irq", 32'(irq), 32'h0);
        rd_chk("R1 reset addr", 0, O_ADDR, 32'h0);
        rd_chk("R1 reset mode", 0, O_MODE, 32'h0);
        rd_chk("R1 reset stat", 0, O_STAT, 32'h0);
        rd_chk("R9 reset flags", 0, O_IFLG, 32'h3);
        wr(2, O_PSEL, 32'hA5);
        rd_chk("R1 stride psel ch2", 2, O_PSEL, 32'hA5);
        rd_chk("R1 stride psel ch1", 1, O_PSEL, 32'h0);
        rd_chk("R1 ctrl write-only", 2, O_CTRL, 32'h0);
    endtask

    task automatic t_linear;
        wr(0, O_ADDR, 32'h1000);
        wr(0, O_MODE, 32'h2);
        wr(0, O_CNT, 32'd3);
        wr(0, O_CTRL, 32'h1);
        rd_chk("R10 enabled stat", 0, O_STAT, 32'h1);
        do_xfer("R2 word 0", 0, 32'h1000, 2'd2, 1'b0);
        do_xfer("R2 word 1", 0, 32'h1004, 2'd2, 1'b0);
        do_xfer("R2 word 2", 0, 32'h1008, 2'd2, 1'b0);
        rd_chk("R2 final addr", 0, O_ADDR, 32'h100C);
        rd_chk("R2 final cnt", 0, O_CNT, 32'h0);
        rd_chk("R9 flags done", 0, O_IFLG, 32'h3);
    endtask

    task automatic t_reload;
        wr(1, O_MODE, 32'h1);
        wr(1, O_ADDR, 32'h2000);
        wr(1, O_CNT, 32'd2);
        wr(1, O_ARLD, 32'h3000);
        wr(1, O_CRLD, 32'd2);
        rd_chk("R9 flags armed", 1, O_IFLG, 32'h0);
        wr(1, O_CTRL, 32'h1);
        do_xfer("R2 half 0", 1, 32'h2000, 2'd1, 1'b0);
        do_xfer("R2 half 1", 1, 32'h2002, 2'd1, 1'b0);
        rd_chk("R3 swapped addr", 1, O_ADDR, 32'h3000);
        rd_chk("R3 swapped cnt", 1, O_CNT, 32'd2);
        rd_chk("R3 queued addr cleared", 1, O_ARLD, 32'h0);
        rd_chk("R3 queued cnt cleared", 1, O_CRLD, 32'h0);
        rd_chk("R9 flags queue empty", 1, O_IFLG, 32'h1);
        do_xfer("R3 after swap", 1, 32'h3000, 2'd1, 1'b0);
    endtask

    task automatic t_immediate;
        wr(2, O_ARLD, 32'h4000);
        wr(2, O_CRLD, 32'd5);
        rd_chk("R4 immediate addr", 2, O_ADDR, 32'h4000);
        rd_chk("R4 immediate cnt", 2, O_CNT, 32'd5);
        rd_chk("R4 queued cnt consumed", 2, O_CRLD, 32'h0);
        rd_chk("R4 queued addr consumed", 2, O_ARLD, 32'h0);
        wr(2, O_CRLD, 32'd7);
        rd_chk("R4 no load when busy cnt", 2, O_CNT, 32'd5);
        rd_chk("R4 queued stored", 2, O_CRLD, 32'd7);
        wr(2, O_CRLD, 32'd0);
    endtask

    task automatic t_ring;
        wr(3, O_MODE, 32'h4);
        wr(3, O_ARLD, 32'h5000);
        wr(3, O_CRLD, 32'd2);
        rd_chk("R4 ring immediate addr", 3, O_ADDR, 32'h5000);
        rd_chk("R5 ring keeps queued cnt", 3, O_CRLD, 32'd2);
        wr(3, O_CTRL, 32'h1);
        do_xfer("R2 byte 0", 3, 32'h5000, 2'd0, 1'b0);
        do_xfer("R2 byte 1", 3, 32'h5001, 2'd0, 1'b0);
        rd_chk("R5 ring wrap addr", 3, O_ADDR, 32'h5000);
        rd_chk("R5 ring queued addr kept", 3, O_ARLD, 32'h5000);
        rd_chk("R5 ring queued cnt kept", 3, O_CRLD, 32'd2);
        do_xfer("R5 ring reuse", 3, 32'h5000, 2'd0, 1'b0);
    endtask

    task automatic t_priority;
        wr(2, O_CTRL, 32'h1);
        @(negedge clk);
        dma_req = 4'b0110;
        for (int i = 0; i < 10 && !xfer_valid; i++) @(negedge clk);
        chk("R6 lower channel first", 32'(xfer_ch), 32'd1);
        chk("R6 ch1 addr", xfer_addr, 32'h3002);
        bus_done = 1'b1;
        @(negedge clk);
        bus_done = 1'b0;
        dma_req[1] = 1'b0;
        for (int i = 0; i < 10 && !xfer_valid; i++) @(negedge clk);
        chk("R6 next channel", 32'(xfer_ch), 32'd2);
        chk("R6 ch2 addr", xfer_addr, 32'h4000);
        bus_done = 1'b1;
        @(negedge clk);
        bus_done = 1'b0;
        dma_req  = '0;
    endtask

    task automatic t_ignore;
        wr(0, O_CNT, 32'd1);
        wr(0, O_CTRL, 32'h2);
        rd_chk("R10 disabled stat", 0, O_STAT, 32'h0);
        @(negedge clk);
        dma_req = 4'b0011;
        repeat (4) @(negedge clk);
        chk("R10 disabled or empty ignored", 32'(xfer_valid), 32'h0);
        dma_req = '0;
        rd_chk("R10 ch1 cnt untouched", 1, O_CNT, 32'h0);
        rd_chk("R10 ch0 addr untouched", 0, O_ADDR, 32'h100C);
    endtask

    task automatic t_error;
        wr(0, O_CTRL, 32'h1);
        wr(0, O_IEN, 32'h4);
        wr(0, O_IEN, 32'h0);
        rd_chk("R9 mask set", 0, O_IMSK, 32'h4);
        do_xfer("R8 error xfer", 0, 32'h100C, 2'd2, 1'b1);
        rd_chk("R8 disabled", 0, O_STAT, 32'h0);
        rd_chk("R8 addr unchanged", 0, O_ADDR, 32'h100C);
        rd_chk("R8 cnt unchanged", 0, O_CNT, 32'd1);
        rd_chk("R8 flag set", 0, O_IFLG, 32'h5);
        chk("R9 irq raised", 32'(irq), 32'h1);
        wr(0, O_IDIS, 32'h0);
        rd_chk("R9 zero disable ignored", 0, O_IMSK, 32'h4);
        chk("R9 irq still raised", 32'(irq), 32'h1);
        wr(0, O_CTRL, 32'h100);
        rd_chk("R8 flag cleared", 0, O_IFLG, 32'h1);
        chk("R9 irq dropped", 32'(irq), 32'h0);
        wr(0, O_IDIS, 32'h4);
        rd_chk("R9 mask cleared", 0, O_IMSK, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_linear();
        t_reload();
        t_immediate();
        t_ring();
        t_priority();
        t_ignore();
        t_error();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R7: actual hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule